// File: doc/BRIEF.md
# One-Wire Byte Transfer Engine

This block moves whole bytes over a one-wire bus by running eight consecutive bit slots per byte, least significant bit first. A byte written to the shared data port is either sent at once, when the engine is idle, or parked in a transmit buffer until the byte on the wire finishes. Each slot is a write-0 slot for a 0 bit or a write-1/read slot for a 1 bit. The level seen on the bus at the sample point of every slot is collected into a received byte.

Reading a byte is the same operation as writing one: software writes all ones, which gives eight read slots, and then collects what the devices on the bus returned. The received byte goes through a holding stage into a receive buffer that software reads and acknowledges. Four status flags report the state of the transmit buffer, the transmit shifter, the receive buffer and the receive holding stage. Slot timing is counted in ticks of an external timebase pulse.

Top module: `owire_byte_engine`

## Requirements
- R1: After reset the status port reads 0x0C: transmit-buffer-empty (bit 2) and transmit-shift-empty (bit 3) set, receive-buffer-full (bit 4) and receive-hold-full (bit 5) clear. The bus is released and the read data is 0x00.
- R2: A written byte goes onto the bus as eight slots, bit 0 first. A 1 bit drives the bus low for LOW1_TICKS ticks and a 0 bit drives it low for LOW0_TICKS ticks.
- R3: Bit i of the received byte is the bus level sampled SAMPLE_TICK ticks into slot i. A write of 0xFF therefore returns the byte that the devices leave on the bus, and a write-0 slot always reads 0.
- R4: When the engine is idle, a write goes straight to the shifter and status bit 2 stays set. A write while a byte is in flight clears status bit 2.
- R5: Status bit 3 clears on the clock edge that accepts a write into an idle engine. It sets again after the eighth slot only if no byte is buffered.
- R6: A byte buffered during a transfer starts on the clock edge that ends the current byte's eighth slot, with no idle gap, and status bit 2 sets on that same edge.
- R7: A received byte reaches the receive buffer one cycle after its eighth slot when the buffer is empty, and status bit 4 sets. A read acknowledge clears bit 4.
- R8: If the receive buffer is still full when a byte completes, that byte is kept in the holding stage and status bit 5 stays set. One cycle after the buffer is acknowledged, the held byte moves into the buffer and bit 5 clears.
- R9: A byte that completes while status bit 5 is set replaces the byte being held.
- R10: The bus is driven low only from the start of a slot for the low time that the bit's value selects. Between slots the bus is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one per slot time unit |
| wr_en | input | 1 | Write strobe for the data port |
| wr_data | input | DATA_W | Byte to send (all ones to read) |
| rd_en | input | 1 | Acknowledge of the receive buffer |
| rd_data | output | DATA_W | Receive buffer contents |
| status | output | 8 | Flags: bit 2 tx buffer empty, bit 3 tx shifter empty, bit 4 rx buffer full, bit 5 rx hold full |
| bus_in | input | 1 | Sampled bus level |
| drive_low | output | 1 | Open-drain pull-down enable |

## Verification
The bench drives a second byte into the buffer while the first is on the wire. It checks that the second byte follows with no gap and in bit-0-first order. A design that swapped bit order, or that dropped or delayed the buffered byte, would show a wrong 16-bit pattern on the bus. Read slots are checked against a bus model that pulls selected bits low, and a mixed byte checks that write-0 slots always read 0; an engine that sampled at the wrong point would return the sent value. The receive path is overfilled without acknowledges. This catches a design that overwrites the buffer, that keeps the oldest held byte instead of the newest, or that leaves the hold flag set after the move. Every low pulse is timed against both allowed lengths.

// File: rtl/owb_pkg.sv
package owb_pkg;
  localparam int STAT_TX_EMPTY  = 2;
  localparam int STAT_TXSR_IDLE = 3;
  localparam int STAT_RX_FULL   = 4;
  localparam int STAT_HOLD_FULL = 5;
  localparam int STAT_W         = 8;
endpackage

// File: rtl/owb_slot.sv
module owb_slot #(
  parameter int LOW0_TICKS  = 56,
  parameter int LOW1_TICKS  = 4,
  parameter int SAMPLE_TICK = 12,
  parameter int SLOT_TICKS  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic start_bit,
  input  logic bus_in,
  output logic done_o,
  output logic sample_o,
  output logic drive_low_o
);
  localparam int CW = $clog2(SLOT_TICKS + 1);

  logic          active_q, active_d;
  logic          bit_q, bit_d;
  logic          smp_q, smp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = active_q && tick && (cnt_q == CW'(SLOT_TICKS - 1));

  always_comb begin
    active_d = active_q;
    bit_d    = bit_q;
    cnt_d    = cnt_q;
    smp_d    = smp_q;
    if (active_q && tick && (cnt_q == CW'(SAMPLE_TICK)))
      smp_d = bus_in;
    if (start) begin
      active_d = 1'b1;
      bit_d    = start_bit;
      cnt_d    = '0;
    end else if (at_end) begin
      active_d = 1'b0;
    end else if (active_q && tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= 1'b1;
      cnt_q    <= '0;
      smp_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      bit_q    <= bit_d;
      cnt_q    <= cnt_d;
      smp_q    <= smp_d;
    end
  end

  assign done_o      = at_end;
  assign sample_o    = smp_q;
  assign drive_low_o = active_q &&
                       (cnt_q < (bit_q ? CW'(LOW1_TICKS) : CW'(LOW0_TICKS)));

  // R10
  low_starts_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low_o) |-> $past(start));

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < CW'(SLOT_TICKS)));
endmodule

// File: rtl/owb_tx.sv
module owb_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slot_done,
  output logic              start_o,
  output logic              start_bit_o,
  output logic              byte_end_o,
  output logic              tx_empty_o,
  output logic              txsr_idle_o
);
  localparam int IW = $clog2(DATA_W);

  logic [DATA_W-1:0] buf_q, buf_d;
  logic              full_q, full_d;
  logic [DATA_W-2:0] sr_q, sr_d;
  logic              busy_q, busy_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              last, take_buf, take_wr, load;
  logic [DATA_W-1:0] load_val;

  assign last     = slot_done && (idx_q == IW'(DATA_W - 1));
  assign take_buf = full_q && last;
  assign take_wr  = wr_en && (!busy_q || (last && !full_q));
  assign load     = take_buf || take_wr;
  assign load_val = take_buf ? buf_q : wr_data;

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    sr_d   = sr_q;
    busy_d = busy_q;
    idx_d  = idx_q;
    if (wr_en && !take_wr) begin
      buf_d  = wr_data;
      full_d = 1'b1;
    end else if (take_buf) begin
      full_d = 1'b0;
    end
    if (load) begin
      sr_d   = load_val[DATA_W-1:1];
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (slot_done) begin
      sr_d  = sr_q >> 1;
      idx_d = idx_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      sr_q   <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      sr_q   <= sr_d;
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign start_o     = load || (slot_done && !last);
  assign start_bit_o = load ? load_val[0] : sr_q[0];
  assign byte_end_o  = last;
  assign tx_empty_o  = !full_q;
  assign txsr_idle_o = !busy_q;

  // R4
  tx_empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty_o) |-> $past(wr_en));

  // R5
  txsr_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txsr_idle_o) |-> $past(wr_en));

  // R6
  tx_empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty_o) |-> ($past(slot_done) && !txsr_idle_o));
endmodule

// File: rtl/owb_rx.sv
module owb_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_done,
  input  logic              bit_val,
  input  logic              byte_end,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_full_o,
  output logic              hold_full_o
);
  logic [DATA_W-2:0] asm_q, asm_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hfull_q, hfull_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              bfull_q, bfull_d;
  logic              move;

  assign move = hfull_q && !bfull_q;

  always_comb begin
    asm_d   = asm_q;
    hold_d  = hold_q;
    hfull_d = hfull_q;
    buf_d   = buf_q;
    bfull_d = bfull_q;
    if (bit_done) asm_d = {bit_val, asm_q[DATA_W-2:1]};
    if (byte_end) begin
      hold_d  = {bit_val, asm_q};
      hfull_d = 1'b1;
    end else if (move) begin
      hfull_d = 1'b0;
    end
    if (move) begin
      buf_d   = hold_q;
      bfull_d = 1'b1;
    end else if (rd_en) begin
      bfull_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q   <= '0;
      hold_q  <= '0;
      hfull_q <= 1'b0;
      buf_q   <= '0;
      bfull_q <= 1'b0;
    end else begin
      asm_q   <= asm_d;
      hold_q  <= hold_d;
      hfull_q <= hfull_d;
      buf_q   <= buf_d;
      bfull_q <= bfull_d;
    end
  end

  assign rd_data_o   = buf_q;
  assign rx_full_o   = bfull_q;
  assign hold_full_o = hfull_q;

  // R7
  rx_full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full_o) |-> $past(rd_en));

  // R8
  hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full_o && !rx_full_o) |=> rx_full_o);

  // R9
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full_o && rx_full_o && !byte_end) |=> $stable(hold_q));
endmodule

// File: rtl/owire_byte_engine.sv
module owire_byte_engine #(
  parameter int DATA_W      = 8,
  parameter int LOW0_TICKS  = 56,
  parameter int LOW1_TICKS  = 4,
  parameter int SAMPLE_TICK = 12,
  parameter int SLOT_TICKS  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      rd_en,
  output logic [DATA_W-1:0]         rd_data,
  output logic [owb_pkg::STAT_W-1:0] status,
  input  logic                      bus_in,
  output logic                      drive_low
);
  import owb_pkg::*;

  logic slot_start, slot_bit, slot_done, slot_sample, byte_end;
  logic tx_empty, txsr_idle, rx_full, hold_full;

  owb_tx #(.DATA_W(DATA_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .slot_done(slot_done), .start_o(slot_start), .start_bit_o(slot_bit),
    .byte_end_o(byte_end), .tx_empty_o(tx_empty), .txsr_idle_o(txsr_idle)
  );

  owb_slot #(
    .LOW0_TICKS(LOW0_TICKS), .LOW1_TICKS(LOW1_TICKS),
    .SAMPLE_TICK(SAMPLE_TICK), .SLOT_TICKS(SLOT_TICKS)
  ) i_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(slot_start),
    .start_bit(slot_bit), .bus_in(bus_in), .done_o(slot_done),
    .sample_o(slot_sample), .drive_low_o(drive_low)
  );

  owb_rx #(.DATA_W(DATA_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .bit_done(slot_done), .bit_val(slot_sample),
    .byte_end(byte_end), .rd_en(rd_en), .rd_data_o(rd_data),
    .rx_full_o(rx_full), .hold_full_o(hold_full)
  );

  always_comb begin
    status                 = '0;
    status[STAT_TX_EMPTY]  = tx_empty;
    status[STAT_TXSR_IDLE] = txsr_idle;
    status[STAT_RX_FULL]   = rx_full;
    status[STAT_HOLD_FULL] = hold_full;
  end
endmodule

// File: tb/test_owire_byte_engine.sv
module test_owire_byte_engine;
  localparam int L0 = 56;
  localparam int L1 = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] status;
  logic       drive_low;
  logic       bus_in;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bus model state
  logic [31:0] resp = 32'hFFFF_FFFF;
  int          slv_base = 0;
  int          slot_n = 0;
  logic        pull_q = 1'b0;
  logic        prev_low = 1'b0;
  int          low_len = 0;
  logic [63:0] seen = '0;
  int          seen_n = 0;
  int          len_err = 0;

  always #2.5 clk = ~clk;

  assign bus_in = !(drive_low || pull_q);

  owire_byte_engine i_owire_byte_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .status(status), .bus_in(bus_in),
    .drive_low(drive_low)
  );

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  always @(negedge clk) begin
    if (drive_low && !prev_low) begin
      pull_q <= !resp[5'(slot_n - slv_base)];
      slot_n <= slot_n + 1;
    end
    if (drive_low) low_len <= low_len + 1;
    if (!drive_low && prev_low) begin
      seen[6'(seen_n)] <= (low_len < 60);
      seen_n <= seen_n + 1;
      if (!((low_len >= 2*L1-2 && low_len <= 2*L1+1) ||
            (low_len >= 2*L0-2 && low_len <= 2*L0+1)))
        len_err <= len_err + 1;
      low_len <= 0;
    end
    prev_low <= drive_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_stat(input int pos, input logic val);
    int n = 0;
    while (status[pos] !== val && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic t_reset();
    chk(status == 8'h0C, "R1 status", status, 8'h0C);
    chk(drive_low == 1'b0, "R1 bus", drive_low, 0);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_write_one(input logic [7:0] b);
    int base;
    resp = 32'hFFFF_FFFF; slv_base = slot_n; base = seen_n;
    put(b);
    chk(status[3] == 1'b0, "R5 shifter busy", status[3], 0);
    chk(status[2] == 1'b1, "R4 idle write bypasses buffer", status[2], 1);
    wait_stat(3, 1'b1);
    chk(seen[6'(base) +: 8] == b, "R2 bit order", seen[6'(base) +: 8], b);
    repeat (2) @(negedge clk);
    chk(status[4] == 1'b1, "R7 rx full", status[4], 1);
    chk(rd_data == b, "R3 echo", rd_data, b);
    ack();
    chk(status[4] == 1'b0, "R7 ack clears", status[4], 0);
  endtask

  task automatic t_read_one(input logic [7:0] tx, input logic [7:0] dev);
    resp = {24'hFFFFFF, dev}; slv_base = slot_n;
    put(tx);
    wait_stat(4, 1'b1);
    chk(rd_data == (tx & dev), "R3 sampled byte", rd_data, tx & dev);
    ack();
  endtask

  task automatic t_back_to_back();
    int base;
    resp = 32'hFFFF_FFFF; slv_base = slot_n; base = seen_n;
    put(8'h12);
    put(8'h34);
    chk(status[2] == 1'b0, "R4 buffered", status[2], 0);
    wait_stat(2, 1'b1);
    chk(seen_n - base == 8, "R6 first byte done", seen_n - base, 8);
    chk(status[3] == 1'b0, "R6 no idle gap", status[3], 0);
    wait_stat(3, 1'b1);
    chk(seen[6'(base) +: 16] == 16'h3412, "R6 sequence", seen[6'(base) +: 16], 16'h3412);
    repeat (2) @(negedge clk);
    chk(status[5] == 1'b1, "R8 hold full", status[5], 1);
    chk(rd_data == 8'h12, "R8 first byte kept", rd_data, 8'h12);
    ack();
    @(negedge clk);
    chk(rd_data == 8'h34, "R8 held moved", rd_data, 8'h34);
    chk(status[5:4] == 2'b01, "R8 flags after move", status[5:4], 2'b01);
    ack();
    chk(status[4] == 1'b0, "R7 empty", status[4], 0);
  endtask

  task automatic t_overwrite();
    resp = 32'hFFFF_FFFF; slv_base = slot_n;
    put(8'h11); wait_stat(3, 1'b1);
    put(8'h22); wait_stat(3, 1'b1);
    put(8'h33); wait_stat(3, 1'b1);
    repeat (2) @(negedge clk);
    chk(rd_data == 8'h11, "R9 buffer untouched", rd_data, 8'h11);
    chk(status[5] == 1'b1, "R9 hold full", status[5], 1);
    ack();
    @(negedge clk);
    chk(rd_data == 8'h33, "R9 newest held", rd_data, 8'h33);
    ack();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_write_one(8'hA5);
    t_write_one(8'h01);
    t_read_one(8'hFF, 8'h3C);
    t_read_one(8'h0F, 8'h55);
    t_back_to_back();
    t_overwrite();
    repeat (10) @(negedge clk);
    // R10
    chk(len_err == 0, "R10 low pulse length", len_err, 0);
    chk(drive_low == 1'b0, "R10 released when idle", drive_low, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule